// File: doc/BRIEF.md
# Time-Division Serial Bus Frame Engine

This block drives the serial side of a four-wire time-division bus. Each frame carries SLOTS octet channels, sent most significant bit first. It can run as timing master or as timing slave. As master it divides the system clock to make a data clock and marks each frame with a sync pulse. As slave it takes both signals from outside, passes them through a synchroniser and follows their rising edges. Each data bit lasts two data-clock periods.

The transmit octets of a whole frame are presented as one parallel word, and the received octets of the last frame come back as another. A one-cycle frame strobe marks the moment the transmit word and the direction mask are taken in and the received word is replaced. Each bit of the direction mask turns one slot around. In a turned slot, the block puts its outgoing bits on the receive pin and listens on the transmit pin. The output pins can be driven push-pull or used as open-drain outputs that only pull low.

All logic runs on the system clock `clk`. The data clock never clocks a register; it is used only as a level that is sampled.

Top module: `iom2_frame_if`

## Requirements
- R1: With `master_i`=1, `dcl_o` is a square wave whose period is 2*CLK_DIV system clocks, and `dcl_oe`=`fs_oe`=1. With `master_i`=0, both enables are 0.
- R2: In master mode, `fs_o` rises in the same cycle as a rising edge of `dcl_o`. It stays high for exactly two data-clock periods and repeats every 2*SLOTS*SLOT_BITS data-clock rising edges (192 with the default parameters).
- R3: `frame_strobe_o` pulses for one cycle at every frame start, and in that same cycle `tx_data_i` and `dir_mask_i` are captured. Bit b of the frame (b = 0 first) is `tx_data_i[FRAME_BITS-1-b]` of the captured word. It is presented from data-clock rising edge 2b to rising edge 2b+2.
- R4: Each bit is sampled at the second data-clock rising edge of its bit time. The bit received as frame bit b appears at `rx_data_o[FRAME_BITS-1-b]` from the next frame start on.
- R5: With `od_mode_i`=1, a 0 bit gives enable 1 and value 0, and a 1 bit gives enable 0. With `od_mode_i`=0, the enable is 1 and the value equals the bit.
- R6: Slot s holds frame bits 8s to 8s+7, and slot 0 is sent first. If bit s of the captured mask is 0, data goes out on `dtx_o`/`dtx_oe`, `drx_oe`=0, and data is sampled from `drx_i`. If the bit is 1, data goes out on `drx_o`/`drx_oe`, `dtx_oe`=0, and data is sampled from `dtx_i`.
- R7: In slave mode, frame position follows the external `dcl_i`/`fs_i` through a SYNC_STAGES-deep synchroniser. A rising edge of `fs_i` starts a frame at the next `dcl_i` rising edge, and receive data is captured as in R4.
- R8: In slave mode, an `fs_i` rising edge that arrives when the count is not at a frame boundary gives a one-cycle `sync_err_o` pulse and restarts the frame. A frame boundary reached with no `fs_i` edge also gives one pulse. An aligned `fs_i` gives none, and master mode never gives one.
- R9: During reset, `dcl_o`, `fs_o`, `frame_strobe_o` and `sync_err_o` are 0 and `rx_data_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate data clock and sync; 0: follow external ones |
| od_mode_i | input | 1 | 1: open-drain data outputs; 0: push-pull |
| dcl_i | input | 1 | External data clock (slave mode) |
| fs_i | input | 1 | External frame sync (slave mode) |
| dcl_o | output | 1 | Generated data clock |
| dcl_oe | output | 1 | Output enable for dcl_o |
| fs_o | output | 1 | Generated frame sync |
| fs_oe | output | 1 | Output enable for fs_o |
| tx_data_i | input | SLOTS*SLOT_BITS | Transmit frame word, first bit in MSB |
| dir_mask_i | input | SLOTS | Per-slot direction reversal mask |
| rx_data_o | output | SLOTS*SLOT_BITS | Last received frame word, first bit in MSB |
| frame_strobe_o | output | 1 | One-cycle frame-start strobe |
| dtx_i | input | 1 | Level read back from the transmit pin |
| dtx_o | output | 1 | Transmit pin value |
| dtx_oe | output | 1 | Transmit pin drive enable |
| drx_i | input | 1 | Level on the receive pin |
| drx_o | output | 1 | Receive pin value in reversed slots |
| drx_oe | output | 1 | Receive pin drive enable |
| sync_err_o | output | 1 | One-cycle frame-sync error pulse |

## Verification
The hardest state to reach from the ports is a slave that has locked onto a frame and then sees a sync edge at the wrong point, or no sync edge at all. The bench acts as an external timing master. It sends two clean frames and cuts the third short with an early sync edge. It then sends a frame that matches the new alignment, and finally stops sending sync. The error pulses are counted after each stage. In master mode, a behavioural model follows the data-clock edges and checks the pins on every clock. Meanwhile the direction mask and drive mode are changed in the middle of frames, so the model must show that the change waits for the next frame start.

// File: rtl/iom2_pkg.sv
package iom2_pkg;

    // Frame-position events produced by the timing engine, valid for one cycle
    typedef struct packed {
        logic rise;     // a data-clock rising edge is taken this cycle
        logic fstart;   // that edge begins a frame (count becomes 0)
        logic sample;   // that edge is the second one of a bit (count becomes odd)
    } iom2_ev_t;

endpackage

// File: rtl/iom2_timing.sv
module iom2_timing
    import iom2_pkg::*;
#(
    parameter  int CLK_DIV     = 33,
    parameter  int FRAME_CYC   = 192,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = $clog2(FRAME_CYC),
    localparam int DW          = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_i,
    input  logic          dcl_i,
    input  logic          fs_i,
    output logic          dcl_o,
    output logic          fs_o,
    output logic [CW-1:0] cnt_o,
    output iom2_ev_t      ev_o,
    output logic          sync_err_o
);

    typedef struct packed {
        logic [DW-1:0]          div;
        logic                   dcl;
        logic                   fs;
        logic [CW-1:0]          cnt;
        logic [SYNC_STAGES-1:0] dsync;
        logic [SYNC_STAGES-1:0] fsync;
        logic                   dprev;
        logic                   fprev;
        logic                   pend;
        logic                   err;
    } tim_st_t;

    tim_st_t       st_d, st_q;
    iom2_ev_t      ev_d;
    logic [CW-1:0] inc_c;
    logic [CW-1:0] nxt_c;
    logic          d_lvl, f_lvl, d_edge, f_edge;

    always_comb begin
        st_d   = st_q;
        st_d.err = 1'b0;
        ev_d   = '0;
        nxt_c  = st_q.cnt;
        inc_c  = (st_q.cnt == CW'(FRAME_CYC - 1)) ? '0 : st_q.cnt + 1'b1;

        // input synchronisers, used in slave mode
        st_d.dsync = {st_q.dsync[SYNC_STAGES-2:0], dcl_i};
        st_d.fsync = {st_q.fsync[SYNC_STAGES-2:0], fs_i};
        d_lvl      = st_q.dsync[SYNC_STAGES-1];
        f_lvl      = st_q.fsync[SYNC_STAGES-1];
        d_edge     = d_lvl & ~st_q.dprev;
        f_edge     = f_lvl & ~st_q.fprev;
        st_d.dprev = d_lvl;
        st_d.fprev = f_lvl;

        if (master_i) begin
            st_d.pend = 1'b0;
            if (st_q.div == DW'(CLK_DIV - 1)) begin
                st_d.div = '0;
                st_d.dcl = ~st_q.dcl;
                if (!st_q.dcl) begin
                    ev_d.rise = 1'b1;
                    nxt_c     = inc_c;
                    st_d.fs   = (inc_c < CW'(2));
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else begin
            st_d.div = '0;
            st_d.dcl = 1'b0;
            st_d.fs  = 1'b0;
            if (d_edge) begin
                ev_d.rise = 1'b1;
                st_d.pend = 1'b0;
                if (f_edge || st_q.pend) begin
                    nxt_c    = '0;
                    st_d.err = (inc_c != '0);   // sync arrived off the boundary
                end else begin
                    nxt_c    = inc_c;
                    st_d.err = (inc_c == '0);   // boundary reached without sync
                end
            end else if (f_edge) begin
                st_d.pend = 1'b1;
            end
        end

        st_d.cnt    = nxt_c;
        ev_d.fstart = ev_d.rise & (nxt_c == '0);
        ev_d.sample = ev_d.rise & nxt_c[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CW'(FRAME_CYC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign dcl_o      = st_q.dcl;
    assign fs_o       = st_q.fs;
    assign cnt_o      = st_q.cnt;
    assign ev_o       = ev_d;
    assign sync_err_o = st_q.err;

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) st_q.cnt < CW'(FRAME_CYC)) else $error("count out of frame"); // R2
    AST_FS_WITH_DCL: assert property (@(posedge clk) disable iff (!rst_n) (master_i && $past(master_i) && $rose(st_q.fs)) |-> $rose(st_q.dcl)) else $error("sync not on clock edge"); // R2
    AST_ERR_ONLY_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) st_q.err |-> !$past(master_i)) else $error("sync error in master mode"); // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) st_q.err |=> !st_q.err) else $error("sync error longer than a cycle"); // R8

endmodule

// File: rtl/iom2_serdes.sv
module iom2_serdes
    import iom2_pkg::*;
#(
    parameter  int SLOTS      = 12,
    parameter  int SLOT_BITS  = 8,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int CW         = $clog2(2 * FRAME_BITS),
    localparam int SW         = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  od_i,
    input  iom2_ev_t              ev_i,
    input  logic [CW-1:0]         cnt_i,
    input  logic [FRAME_BITS-1:0] tx_data_i,
    input  logic [SLOTS-1:0]      dir_mask_i,
    input  logic                  dtx_i,
    input  logic                  drx_i,
    output logic                  dtx_o,
    output logic                  dtx_oe_o,
    output logic                  drx_o,
    output logic                  drx_oe_o,
    output logic [FRAME_BITS-1:0] rx_data_o,
    output logic                  frame_strobe_o
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] txb;
        logic [SLOTS-1:0]      mask;
        logic [FRAME_BITS-1:0] rxsh;
        logic [FRAME_BITS-1:0] rxout;
        logic                  strobe;
    } sd_st_t;

    sd_st_t        st_d, st_q;
    logic [SW-1:0] slot_c;
    logic          rev_c;
    logic          bit_c;
    logic          pin_c;
    logic          oe_c;
    logic          val_c;

    always_comb begin
        slot_c = SW'(cnt_i / (2 * SLOT_BITS));
        rev_c  = st_q.mask[slot_c];
        bit_c  = st_q.txb[FRAME_BITS-1];
        pin_c  = rev_c ? dtx_i : drx_i;

        st_d        = st_q;
        st_d.strobe = 1'b0;

        if (ev_i.fstart) begin
            st_d.txb    = tx_data_i;
            st_d.mask   = dir_mask_i;
            st_d.rxout  = st_q.rxsh;
            st_d.strobe = 1'b1;
        end else if (ev_i.rise && !ev_i.sample) begin
            st_d.txb = {st_q.txb[FRAME_BITS-2:0], 1'b0};
        end

        if (ev_i.sample) begin
            st_d.rxsh = {st_q.rxsh[FRAME_BITS-2:0], pin_c};
        end

        // drive style: open-drain only pulls low
        oe_c  = od_i ? ~bit_c : 1'b1;
        val_c = od_i ? 1'b0 : bit_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dtx_o          = val_c;
    assign drx_o          = val_c;
    assign dtx_oe_o       = oe_c & ~rev_c;
    assign drx_oe_o       = oe_c & rev_c;
    assign rx_data_o      = st_q.rxout;
    assign frame_strobe_o = st_q.strobe;

    AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) drx_oe_o |-> !dtx_oe_o) else $error("both data pins driven"); // R6
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (od_i && (dtx_oe_o || drx_oe_o)) |-> !val_c) else $error("open-drain drove high"); // R5
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) st_q.strobe |=> !st_q.strobe) else $error("strobe held"); // R3

endmodule

// File: rtl/iom2_frame_if.sv
module iom2_frame_if
    import iom2_pkg::*;
#(
    parameter  int SLOTS       = 12,
    parameter  int SLOT_BITS   = 8,
    parameter  int CLK_DIV     = 33,
    parameter  int SYNC_STAGES = 2,
    localparam int FRAME_BITS  = SLOTS * SLOT_BITS,
    localparam int FRAME_CYC   = 2 * FRAME_BITS,
    localparam int CW          = $clog2(FRAME_CYC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_i,
    input  logic                  od_mode_i,
    input  logic                  dcl_i,
    input  logic                  fs_i,
    output logic                  dcl_o,
    output logic                  dcl_oe,
    output logic                  fs_o,
    output logic                  fs_oe,
    input  logic [FRAME_BITS-1:0] tx_data_i,
    input  logic [SLOTS-1:0]      dir_mask_i,
    output logic [FRAME_BITS-1:0] rx_data_o,
    output logic                  frame_strobe_o,
    input  logic                  dtx_i,
    output logic                  dtx_o,
    output logic                  dtx_oe,
    input  logic                  drx_i,
    output logic                  drx_o,
    output logic                  drx_oe,
    output logic                  sync_err_o
);

    iom2_ev_t      ev;
    logic [CW-1:0] cnt;

    iom2_timing #(
        .CLK_DIV    (CLK_DIV),
        .FRAME_CYC  (FRAME_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_i  (master_i),
        .dcl_i     (dcl_i),
        .fs_i      (fs_i),
        .dcl_o     (dcl_o),
        .fs_o      (fs_o),
        .cnt_o     (cnt),
        .ev_o      (ev),
        .sync_err_o(sync_err_o)
    );

    iom2_serdes #(
        .SLOTS    (SLOTS),
        .SLOT_BITS(SLOT_BITS)
    ) u_serdes (
        .clk           (clk),
        .rst_n         (rst_n),
        .od_i          (od_mode_i),
        .ev_i          (ev),
        .cnt_i         (cnt),
        .tx_data_i     (tx_data_i),
        .dir_mask_i    (dir_mask_i),
        .dtx_i         (dtx_i),
        .drx_i         (drx_i),
        .dtx_o         (dtx_o),
        .dtx_oe_o      (dtx_oe),
        .drx_o         (drx_o),
        .drx_oe_o      (drx_oe),
        .rx_data_o     (rx_data_o),
        .frame_strobe_o(frame_strobe_o)
    );

    assign dcl_oe = master_i;
    assign fs_oe  = master_i;

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !master_i |-> (!dcl_oe && !fs_oe)) else $error("timing driven in slave mode"); // R1

endmodule

// File: tb/iom2_frame_if_tb.sv
module iom2_frame_if_tb_top;

    localparam int SLOTS = 12;
    localparam int SB    = 8;
    localparam int DIV   = 2;
    localparam int FB    = SLOTS * SB;
    localparam int FC    = 2 * FB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master = 1'b1;
    logic od = 1'b0;
    logic s_dcl = 1'b0, s_fs = 1'b0, s_drx = 1'b0;
    logic m_dtx = 1'b1, m_drx = 1'b1;
    logic mon_en = 1'b0;
    logic slv_en = 1'b0;
    logic [FB-1:0]    tx_data = '0;
    logic [SLOTS-1:0] mask = '0;

    logic dcl_o, dcl_oe, fs_o, fs_oe, frame_strobe, dtx_o, dtx_oe, drx_o, drx_oe, sync_err;
    logic [FB-1:0] rx_data;
    logic dtx_i, drx_i;

    assign dtx_i = mon_en ? m_dtx : 1'b1;
    assign drx_i = mon_en ? m_drx : s_drx;

    always #5 clk = ~clk;

    iom2_frame_if #(.SLOTS(SLOTS), .SLOT_BITS(SB), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_i(master), .od_mode_i(od),
        .dcl_i(s_dcl), .fs_i(s_fs), .dcl_o(dcl_o), .dcl_oe(dcl_oe),
        .fs_o(fs_o), .fs_oe(fs_oe), .tx_data_i(tx_data), .dir_mask_i(mask),
        .rx_data_o(rx_data), .frame_strobe_o(frame_strobe),
        .dtx_i(dtx_i), .dtx_o(dtx_o), .dtx_oe(dtx_oe),
        .drx_i(drx_i), .drx_o(drx_o), .drx_oe(drx_oe), .sync_err_o(sync_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int err_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [FB-1:0] act, input logic [FB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [FB-1:0] pat(input int f);
        logic [FB-1:0] p;
        p = {32'hC3A5_0F1E ^ (32'h0101_0101 * f), 32'h5A5A_9669 + f, ~(32'h1234_5678 << (f % 8))};
        return p;
    endfunction

    always @(negedge clk) if (rst_n) err_cnt += int'(sync_err);

    // ---------------- master-mode reference model ----------------
    logic          prev_dcl = 1'b0;
    int            clkn = 0, last_rise = -1, pos = -1, frames = 0;
    logic [FB-1:0] lat_tx = '0, cur_pat = '0;
    logic [SLOTS-1:0] lat_mask = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            clkn++;
            chk(dcl_oe && fs_oe, "R1 enables in master", FB'({dcl_oe, fs_oe}), FB'(3));
            if (dcl_o && !prev_dcl) begin
                if (last_rise >= 0)
                    chk(clkn - last_rise == 2 * DIV, "R1 data clock period", FB'(clkn - last_rise), FB'(2 * DIV));
                last_rise = clkn;
                if (pos >= 0) pos = (pos + 1) % FC;
                else if (fs_o) pos = 0;
                if (pos >= 0) begin
                    chk(fs_o == (pos < 2), "R2 frame sync position", FB'(fs_o), FB'(pos < 2));
                    if (pos == 0) begin
                        chk(frame_strobe, "R3 strobe at frame start", FB'(frame_strobe), FB'(1));
                        if (frames >= 1)
                            chk(rx_data == cur_pat, "R4 received frame", rx_data, cur_pat);
                        lat_tx   = tx_data;
                        lat_mask = mask;
                        cur_pat  = pat(frames);
                        frames++;
                    end else begin
                        chk(!frame_strobe, "R3 no strobe mid frame", FB'(frame_strobe), FB'(0));
                    end
                    if (pos % 2 == 0) begin
                        if (lat_mask[(pos / 2) / SB]) begin
                            m_dtx = cur_pat[FB - 1 - pos / 2];
                            m_drx = ~cur_pat[FB - 1 - pos / 2];
                        end else begin
                            m_drx = cur_pat[FB - 1 - pos / 2];
                            m_dtx = ~cur_pat[FB - 1 - pos / 2];
                        end
                    end
                end
            end else if (pos >= 0) begin
                chk(!frame_strobe, "R3 strobe is one pulse", FB'(frame_strobe), FB'(0));
            end
            if (pos >= 0) begin : pin_cmp
                logic b, rev, e_oe, e_o;
                b    = lat_tx[FB - 1 - pos / 2];
                rev  = lat_mask[(pos / 2) / SB];
                e_oe = od ? ~b : 1'b1;
                e_o  = od ? 1'b0 : b;
                chk(dtx_oe == (e_oe & ~rev) && drx_oe == (e_oe & rev), "R6 R5 pin enables",
                    FB'({dtx_oe, drx_oe}), FB'({e_oe & ~rev, e_oe & rev}));
                if (dtx_oe || drx_oe)
                    chk((rev ? drx_o : dtx_o) == e_o, "R3 R5 serial value", FB'(rev ? drx_o : dtx_o), FB'(e_o));
            end
            prev_dcl = dcl_o;
        end
    end

    // ---------------- slave-mode stimulus ----------------
    logic [FB-1:0] slv_q[$];
    always @(negedge clk) if (slv_en && frame_strobe) slv_q.push_back(rx_data);

    task automatic srise(input bit fsl, input bit d);
        @(negedge clk);
        s_dcl = 1'b1; s_fs = fsl; s_drx = d;
        repeat (4) @(negedge clk);
        s_dcl = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sframe(input int nr, input bit with_fs, input logic [FB-1:0] p);
        for (int k = 0; k < nr; k++)
            srise(with_fs && (k < 2), p[FB - 1 - (k / 2)]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dcl_o && !fs_o && !frame_strobe && !sync_err, "R9 outputs in reset",
            FB'({dcl_o, fs_o, frame_strobe, sync_err}), FB'(0));
        chk(rx_data == '0, "R9 receive word in reset", rx_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : main
        int e0;
        // master phase
        master = 1'b1; od = 1'b0; mask = '0; tx_data = pat(100);
        do_reset();
        mon_en = 1'b1;
        repeat (900) @(negedge clk);
        #1 tx_data = pat(101); mask = 12'hA05;
        repeat (800) @(negedge clk);
        #1 od = 1'b1;
        repeat (800) @(negedge clk);
        #1 tx_data = pat(102); mask = 12'hFFF;
        repeat (800) @(negedge clk);
        #1 mask = 12'h0F0; tx_data = pat(103); od = 1'b0;
        repeat (1600) @(negedge clk);
        chk(frames >= 6, "R2 frames observed", FB'(frames), FB'(6));
        chk(err_cnt == 0, "R8 no error in master", FB'(err_cnt), FB'(0));
        mon_en = 1'b0;

        // slave phase
        @(negedge clk);
        master = 1'b0; mask = '0;
        do_reset();
        err_cnt = 0;
        slv_en = 1'b1;
        chk(!dcl_oe && !fs_oe, "R1 enables in slave", FB'({dcl_oe, fs_oe}), FB'(0));
        sframe(FC, 1'b1, pat(1));
        sframe(FC, 1'b1, pat(2));
        sframe(100, 1'b1, pat(3));
        chk(err_cnt == 0, "R8 aligned sync gives no error", FB'(err_cnt), FB'(0));
        chk(slv_q.size() >= 3, "R7 strobes in slave", FB'(slv_q.size()), FB'(3));
        if (slv_q.size() >= 3) begin
            chk(slv_q[1] == pat(1), "R7 slave receive frame 1", slv_q[1], pat(1));
            chk(slv_q[2] == pat(2), "R7 slave receive frame 2", slv_q[2], pat(2));
        end
        e0 = err_cnt;
        sframe(FC, 1'b1, pat(4));
        chk(err_cnt - e0 == 1, "R8 early sync flagged once", FB'(err_cnt - e0), FB'(1));
        e0 = err_cnt;
        sframe(FC, 1'b1, pat(5));
        chk(err_cnt - e0 == 0, "R8 realigned sync accepted", FB'(err_cnt - e0), FB'(0));
        e0 = err_cnt;
        sframe(4, 1'b0, pat(6));
        chk(err_cnt - e0 == 1, "R8 missing sync flagged", FB'(err_cnt - e0), FB'(1));
        slv_en = 1'b0;

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        #1_500_000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule